// File: doc/BRIEF.md
# Multi-Source Reset Distribution Controller

This block collects every reset request that can reach a network controller and turns them into one reset line per internal domain. The domains are the wake/PME logic, the PHY, the non-volatile configuration loader, the host configuration registers, the subsystem identifier registers, the MAC, the DMA engines and the system control registers. The requests are power-on reset, host bus reset, pulses marking entry to and exit from the D3hot power state, and three self-clearing request bits: a software reset, a hard PHY reset and a PHY soft reset.

Each domain output is active high. The asynchronous sources assert it at once and release it through a synchroniser. Every domain output then holds for a fixed stretch after its last request before it releases on a clock edge. Two qualifier outputs tell register banks whether the reset under way is a soft one. When it is, bits that are kept across a software reset must hold their value. The wake configuration and the D3hot entry history decide whether the PME and PHY domains take part.

Top module: `rst_dist_ctrl`

## Requirements
- R1: While power-on reset (rst_ni low) is asserted, all eight domain outputs are high at once, and all three request bits and both keep qualifiers are low.
- R2: A software reset write asserts the MAC, DMA and system-register domains from the next cycle, with sys_keep_o high. The PHY, loader, host-config, subsystem-ID and PME domains are untouched.
- R3: A hard PHY reset write asserts only the PHY domain from the next cycle, with phy_keep_o low. This includes a soft PHY write that arrives while the hard reset runs.
- R4: A PHY soft reset write asserts only the PHY domain, with phy_keep_o high.
- R5: Host bus reset asserts every domain at once when D3cold wake is disabled. When D3cold wake is enabled it asserts every domain except PME.
- R6: A D3hot entry pulse resets the PHY domain, and no other domain, exactly when aux_pwr_det_i is low or pme_en_i is low.
- R7: A D3hot exit pulse resets the PHY only if the last entry reset it. The entry record is cleared by the exit.
- R8: A D3hot exit pulse resets the loader, host-config, MAC, DMA and system-register domains, with sys_keep_o low. It leaves the subsystem-ID and PME domains alone.
- R9: A domain output sampled in the cycle after a request stays high for exactly 16 samples and then drops. After an asynchronous source releases, outputs drop 18 cycles later: 2 synchroniser cycles and then 16.
- R10: Each request bit reads 1 from the cycle after its write and clears in the cycle after its domain reset drops. A repeat write while the bit is set does not extend the reset. Power-on or host reset clears the bit at once.
- R11: busy_o is high while any domain output or request bit is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| host_rst_ni | input | 1 | Host bus reset, active low, asynchronous |
| d3cold_wake_en_i | input | 1 | D3cold wake supported; exempts PME from host reset |
| aux_pwr_det_i | input | 1 | Auxiliary power present |
| pme_en_i | input | 1 | PME enable from power-management status |
| d3hot_entry_i | input | 1 | One-cycle pulse: entering D3hot |
| d3hot_exit_i | input | 1 | One-cycle pulse: leaving D3hot |
| sw_rst_set_i | input | 1 | Write of 1 to the software reset bit |
| phy_rst_set_i | input | 1 | Write of 1 to the hard PHY reset bit |
| phy_srst_set_i | input | 1 | Write of 1 to the PHY soft reset bit |
| pme_rst_o | output | 1 | Reset of wake/PME logic |
| phy_rst_o | output | 1 | Reset of the PHY |
| nvld_rst_o | output | 1 | Reset of the configuration loader |
| hcfg_rst_o | output | 1 | Reset of host configuration registers |
| mac_rst_o | output | 1 | Reset of the MAC |
| dma_rst_o | output | 1 | Reset of the DMA engines |
| sys_rst_o | output | 1 | Reset of system control registers |
| ssid_rst_o | output | 1 | Reset of subsystem ID registers |
| sys_keep_o | output | 1 | System-register reset is soft; preserved bits hold |
| phy_keep_o | output | 1 | PHY reset is soft; preserved PHY bits hold |
| sw_rst_bit_o | output | 1 | Software reset bit readback |
| phy_rst_bit_o | output | 1 | Hard PHY reset bit readback |
| phy_srst_bit_o | output | 1 | PHY soft reset bit readback |
| busy_o | output | 1 | Any reset or request bit active |

## Verification
A lost or stale D3hot entry record shows up at the next exit pulse: the PHY output either rises when it should stay low or stays low when it should rise, one cycle after the pulse. A stretch counter with the wrong value changes how long an output is held. This is visible as a hold that is not exactly 16 samples, and as a request bit that clears early or late. A cause tracker with the wrong value shows a keep qualifier with the wrong level in the first cycle of the reset.

// File: rtl/rst_dist_pkg.sv
package rst_dist_pkg;
  typedef enum int unsigned {
    DOM_PME  = 0,
    DOM_PHY  = 1,
    DOM_NVLD = 2,
    DOM_HCFG = 3,
    DOM_MAC  = 4,
    DOM_DMA  = 5,
    DOM_SYS  = 6,
    DOM_SSID = 7
  } dom_e;

  localparam int unsigned NUM_DOM = 8;
  localparam int unsigned NUM_BIT = 3;
  localparam int unsigned BIT_SW   = 0;
  localparam int unsigned BIT_PHY  = 1;
  localparam int unsigned BIT_PSRT = 2;

  // domains that host reset spares when D3cold wake is supported
  localparam logic [NUM_DOM-1:0] WAKE_EXEMPT = 8'b0000_0001;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) q <= '0;
    else          q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned STRETCH = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic req_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(STRETCH + 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q <= CW'(STRETCH);
      rst_q <= 1'b1;
    end else if (req_i) begin
      cnt_q <= CW'(STRETCH);
      rst_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      rst_q <= (cnt_q > CW'(1));
    end
  end

  assign rst_o = rst_q;
endmodule

// File: rtl/rst_req_bit.sv
module rst_req_bit (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic set_i,
  input  logic dom_rst_i,
  output logic bit_o,
  output logic req_o
);
  logic bit_q, prev_q;

  // a write while set is dropped, so it cannot extend the reset
  assign req_o = set_i & ~bit_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      bit_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= dom_rst_i;
      if (req_o)                              bit_q <= 1'b1;
      else if (bit_q && prev_q && !dom_rst_i) bit_q <= 1'b0;
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/rst_keep_track.sv
module rst_keep_track (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic hard_i,
  input  logic soft_i,
  input  logic rst_i,
  output logic keep_o
);
  logic keep_q;

  // a hard cause at any point makes the whole running reset hard
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)               keep_q <= 1'b0;
    else if (hard_i)            keep_q <= 1'b0;
    else if (soft_i && !rst_i)  keep_q <= 1'b1;
  end

  assign keep_o = keep_q & rst_i;
endmodule

// File: rtl/rst_dist_ctrl.sv
module rst_dist_ctrl
  import rst_dist_pkg::*;
#(
  parameter int unsigned STRETCH     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_rst_ni,
  input  logic d3cold_wake_en_i,
  input  logic aux_pwr_det_i,
  input  logic pme_en_i,
  input  logic d3hot_entry_i,
  input  logic d3hot_exit_i,
  input  logic sw_rst_set_i,
  input  logic phy_rst_set_i,
  input  logic phy_srst_set_i,
  output logic pme_rst_o,
  output logic phy_rst_o,
  output logic nvld_rst_o,
  output logic hcfg_rst_o,
  output logic mac_rst_o,
  output logic dma_rst_o,
  output logic sys_rst_o,
  output logic ssid_rst_o,
  output logic sys_keep_o,
  output logic phy_keep_o,
  output logic sw_rst_bit_o,
  output logic phy_rst_bit_o,
  output logic phy_srst_bit_o,
  output logic busy_o
);
  logic                por_n_s, host_n_s, ctl_arst_n;
  logic [NUM_DOM-1:0]  dom_req, dom_rst, dom_arst_n;
  logic [NUM_BIT-1:0]  bit_set, bit_dom, bit_q, bit_req;
  logic                d3_flag_q, phy_on_entry, d3_entry_phy, d3_exit_phy;

  rst_sync #(.STAGES(SYNC_STAGES)) u_sync_por (
    .clk_i(clk_i), .arst_ni(rst_ni), .rst_no(por_n_s));

  rst_sync #(.STAGES(SYNC_STAGES)) u_sync_host (
    .clk_i(clk_i), .arst_ni(host_rst_ni & rst_ni), .rst_no(host_n_s));

  assign ctl_arst_n = por_n_s & host_n_s;

  // request bits: software, hard PHY, soft PHY
  assign bit_set = {phy_srst_set_i, phy_rst_set_i, sw_rst_set_i};
  assign bit_dom = {dom_rst[DOM_PHY], dom_rst[DOM_PHY], dom_rst[DOM_SYS]};

  for (genvar b = 0; b < NUM_BIT; b++) begin : g_bit
    rst_req_bit u_bit (
      .clk_i    (clk_i),
      .arst_ni  (ctl_arst_n),
      .set_i    (bit_set[b]),
      .dom_rst_i(bit_dom[b]),
      .bit_o    (bit_q[b]),
      .req_o    (bit_req[b])
    );
  end

  // D3hot PHY entry record
  assign phy_on_entry = ~aux_pwr_det_i | ~pme_en_i;
  assign d3_entry_phy = d3hot_entry_i & phy_on_entry;
  assign d3_exit_phy  = d3hot_exit_i & d3_flag_q;

  always_ff @(posedge clk_i or negedge ctl_arst_n) begin
    if (!ctl_arst_n)        d3_flag_q <= 1'b0;
    else if (d3hot_entry_i) d3_flag_q <= phy_on_entry;
    else if (d3hot_exit_i)  d3_flag_q <= 1'b0;
  end

  always_comb begin
    dom_req           = '0;
    dom_req[DOM_PHY]  = bit_req[BIT_PHY] | bit_req[BIT_PSRT] | d3_entry_phy | d3_exit_phy;
    dom_req[DOM_NVLD] = d3hot_exit_i;
    dom_req[DOM_HCFG] = d3hot_exit_i;
    dom_req[DOM_MAC]  = d3hot_exit_i | bit_req[BIT_SW];
    dom_req[DOM_DMA]  = d3hot_exit_i | bit_req[BIT_SW];
    dom_req[DOM_SYS]  = d3hot_exit_i | bit_req[BIT_SW];
  end

  // wake config is quasi-static; it only gates the host term
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign dom_arst_n[d] = por_n_s & (host_n_s | (WAKE_EXEMPT[d] & d3cold_wake_en_i));

    rst_stretch #(.STRETCH(STRETCH)) u_str (
      .clk_i  (clk_i),
      .arst_ni(dom_arst_n[d]),
      .req_i  (dom_req[d]),
      .rst_o  (dom_rst[d])
    );
  end

  rst_keep_track u_keep_sys (
    .clk_i  (clk_i),
    .arst_ni(dom_arst_n[DOM_SYS]),
    .hard_i (d3hot_exit_i),
    .soft_i (bit_req[BIT_SW]),
    .rst_i  (dom_rst[DOM_SYS]),
    .keep_o (sys_keep_o)
  );

  rst_keep_track u_keep_phy (
    .clk_i  (clk_i),
    .arst_ni(dom_arst_n[DOM_PHY]),
    .hard_i (bit_req[BIT_PHY] | d3_entry_phy | d3_exit_phy),
    .soft_i (bit_req[BIT_PSRT]),
    .rst_i  (dom_rst[DOM_PHY]),
    .keep_o (phy_keep_o)
  );

  assign pme_rst_o      = dom_rst[DOM_PME];
  assign phy_rst_o      = dom_rst[DOM_PHY];
  assign nvld_rst_o     = dom_rst[DOM_NVLD];
  assign hcfg_rst_o     = dom_rst[DOM_HCFG];
  assign mac_rst_o      = dom_rst[DOM_MAC];
  assign dma_rst_o      = dom_rst[DOM_DMA];
  assign sys_rst_o      = dom_rst[DOM_SYS];
  assign ssid_rst_o     = dom_rst[DOM_SSID];
  assign sw_rst_bit_o   = bit_q[BIT_SW];
  assign phy_rst_bit_o  = bit_q[BIT_PHY];
  assign phy_srst_bit_o = bit_q[BIT_PSRT];
  assign busy_o         = (|dom_rst) | (|bit_q);
endmodule

// File: rtl/rst_dist_chk.sv
module rst_dist_chk #(
  parameter int unsigned STRETCH = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic host_rst_ni,
  input logic d3cold_wake_en_i,
  input logic aux_pwr_det_i,
  input logic pme_en_i,
  input logic d3hot_entry_i,
  input logic d3hot_exit_i,
  input logic sw_rst_set_i,
  input logic phy_rst_set_i,
  input logic phy_srst_set_i,
  input logic pme_rst_o,
  input logic phy_rst_o,
  input logic nvld_rst_o,
  input logic hcfg_rst_o,
  input logic mac_rst_o,
  input logic dma_rst_o,
  input logic sys_rst_o,
  input logic ssid_rst_o,
  input logic sys_keep_o,
  input logic phy_keep_o,
  input logic sw_rst_bit_o,
  input logic busy_o
);
  localparam int unsigned HW = $clog2(STRETCH + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hi_cnt <= '0;
    else if (!mac_rst_o)              hi_cnt <= '0;
    else if (hi_cnt < HW'(STRETCH))   hi_cnt <= hi_cnt + 1'b1;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      AST_POR_ALL: assert (pme_rst_o && phy_rst_o && nvld_rst_o && hcfg_rst_o &&
                           mac_rst_o && dma_rst_o && sys_rst_o && ssid_rst_o &&
                           !sw_rst_bit_o && !sys_keep_o && !phy_keep_o); // R1
    end
  end

  AST_SW_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni || !host_rst_ni)
    sw_rst_set_i && !busy_o && !d3hot_exit_i |=>
    mac_rst_o && dma_rst_o && sys_rst_o && sys_keep_o && !nvld_rst_o && !hcfg_rst_o); // R2

  AST_PHY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni || !host_rst_ni)
    phy_rst_set_i && !busy_o && !sw_rst_set_i && !d3hot_exit_i |=>
    phy_rst_o && !phy_keep_o && !mac_rst_o && !sys_rst_o); // R3

  AST_SOFT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni || !host_rst_ni)
    phy_srst_set_i && !busy_o && !phy_rst_set_i && !d3hot_entry_i && !d3hot_exit_i |=>
    phy_rst_o && phy_keep_o); // R4

  AST_PME_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d3cold_wake_en_i && $past(d3cold_wake_en_i) && !$past(pme_rst_o) |-> !pme_rst_o); // R5

  AST_D3_ENTRY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni || !host_rst_ni)
    d3hot_entry_i && aux_pwr_det_i && pme_en_i && !busy_o &&
    !phy_rst_set_i && !phy_srst_set_i && !d3hot_exit_i |=> !phy_rst_o); // R6

  AST_D3_EXIT_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni || !host_rst_ni)
    d3hot_exit_i && !busy_o |=>
    hcfg_rst_o && nvld_rst_o && !ssid_rst_o && !pme_rst_o && !sys_keep_o); // R8

  AST_MIN_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mac_rst_o) |-> hi_cnt >= HW'(STRETCH)); // R9

  AST_BIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni || !host_rst_ni)
    $fell(sys_rst_o) && !sw_rst_set_i |=> !sw_rst_bit_o); // R10
endmodule

bind rst_dist_ctrl rst_dist_chk #(.STRETCH(STRETCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_rst_ni(host_rst_ni),
  .d3cold_wake_en_i(d3cold_wake_en_i), .aux_pwr_det_i(aux_pwr_det_i),
  .pme_en_i(pme_en_i), .d3hot_entry_i(d3hot_entry_i), .d3hot_exit_i(d3hot_exit_i),
  .sw_rst_set_i(sw_rst_set_i), .phy_rst_set_i(phy_rst_set_i),
  .phy_srst_set_i(phy_srst_set_i), .pme_rst_o(pme_rst_o), .phy_rst_o(phy_rst_o),
  .nvld_rst_o(nvld_rst_o), .hcfg_rst_o(hcfg_rst_o), .mac_rst_o(mac_rst_o),
  .dma_rst_o(dma_rst_o), .sys_rst_o(sys_rst_o), .ssid_rst_o(ssid_rst_o),
  .sys_keep_o(sys_keep_o), .phy_keep_o(phy_keep_o), .sw_rst_bit_o(sw_rst_bit_o),
  .busy_o(busy_o));

// File: tb/rst_dist_ctrl_bench.sv
module rst_dist_ctrl_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0, host_rst_ni = 1'b1, d3cold = 1'b0, aux = 1'b1, pme_en = 1'b1;
  logic entry = 1'b0, exit_p = 1'b0, sw_set = 1'b0, phy_set = 1'b0, psrt_set = 1'b0;
  logic pme_r, phy_r, nvld_r, hcfg_r, mac_r, dma_r, sys_r, ssid_r;
  logic sys_keep, phy_keep, sw_bit, phy_bit, psrt_bit, busy;
  logic [7:0] dom;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [7:0] M_ALL = 8'hFF, M_SW = 8'h70, M_EXIT = 8'h7C, M_PHY = 8'h02;

  always #5 clk = ~clk;

  assign dom = {ssid_r, sys_r, dma_r, mac_r, hcfg_r, nvld_r, phy_r, pme_r};

  rst_dist_ctrl u_rst_dist_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .host_rst_ni(host_rst_ni),
    .d3cold_wake_en_i(d3cold), .aux_pwr_det_i(aux), .pme_en_i(pme_en),
    .d3hot_entry_i(entry), .d3hot_exit_i(exit_p), .sw_rst_set_i(sw_set),
    .phy_rst_set_i(phy_set), .phy_srst_set_i(psrt_set),
    .pme_rst_o(pme_r), .phy_rst_o(phy_r), .nvld_rst_o(nvld_r), .hcfg_rst_o(hcfg_r),
    .mac_rst_o(mac_r), .dma_rst_o(dma_r), .sys_rst_o(sys_r), .ssid_rst_o(ssid_r),
    .sys_keep_o(sys_keep), .phy_keep_o(phy_keep), .sw_rst_bit_o(sw_bit),
    .phy_rst_bit_o(phy_bit), .phy_srst_bit_o(psrt_bit), .busy_o(busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // which: 0 sw, 1 hard phy, 2 soft phy, 3 d3 entry, 4 d3 exit
  task automatic fire(input int which);
    @(negedge clk);
    case (which)
      0: sw_set = 1'b1;
      1: phy_set = 1'b1;
      2: psrt_set = 1'b1;
      3: entry = 1'b1;
      default: exit_p = 1'b1;
    endcase
    @(negedge clk);
    {sw_set, phy_set, psrt_set, entry, exit_p} = '0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 60) begin n++; @(negedge clk); end
    chk({tag, " idle"}, busy, 1'b0);
  endtask

  task automatic run_len(input int idx, output int n);
    n = 0;
    while (dom[idx] && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic t_por();
    int n;
    @(negedge clk);
    chk("R1 domains", dom, M_ALL);
    chk("R1 bits/keep", {sw_bit, phy_bit, psrt_bit, sys_keep, phy_keep}, 5'b0);
    chk("R11 busy in reset", busy, 1'b1);
    rst_ni = 1'b1;
    repeat (17) @(posedge clk);
    @(negedge clk);
    chk("R9 held after release", dom, M_ALL);
    @(posedge clk); @(negedge clk);
    chk("R9 released at 18", dom, 8'h00);
    chk("R11 busy idle", busy, 1'b0);
  endtask

  task automatic t_sw();
    int n;
    fire(0);
    chk("R2 map", dom, M_SW);
    chk("R2 keep", {sys_keep, phy_keep}, 2'b10);
    chk("R10 bit set", sw_bit, 1'b1);
    chk("R11 busy", busy, 1'b1);
    run_len(6, n);
    chk("R9 sw length", n, 16);
    chk("R10 bit held one cycle", sw_bit, 1'b1);
    @(negedge clk);
    chk("R10 bit cleared", sw_bit, 1'b0);
    chk("R11 busy clear", busy, 1'b0);
  endtask

  task automatic t_sw_rewrite();
    int n = 0;
    fire(0);
    while (sys_r && n < 100) begin
      n++;
      sw_set = (n == 5);
      @(negedge clk);
    end
    sw_set = 1'b0;
    chk("R10 rewrite ignored length", n, 16);
    wait_idle("R10");
  endtask

  task automatic t_phy_hard();
    int n;
    fire(1);
    chk("R3 map", dom, M_PHY);
    chk("R3 keep low", phy_keep, 1'b0);
    chk("R10 phy bit", phy_bit, 1'b1);
    fire(2);
    chk("R3 soft during hard keep low", phy_keep, 1'b0);
    wait_idle("R3");
    chk("R10 phy bits clear", {phy_bit, psrt_bit}, 2'b00);
  endtask

  task automatic t_phy_soft();
    int n;
    fire(2);
    chk("R4 map", dom, M_PHY);
    chk("R4 keep high", {phy_keep, sys_keep}, 2'b10);
    run_len(1, n);
    chk("R9 phy length", n, 16);
    wait_idle("R4");
  endtask

  task automatic t_host(input logic wake);
    d3cold = wake;
    fire(0);
    @(negedge clk);
    host_rst_ni = 1'b0;
    #1;
    chk(wake ? "R5 host wake-exempt" : "R5 host all", dom, wake ? 8'hFE : M_ALL);
    chk("R10 host clears bit", sw_bit, 1'b0);
    @(negedge clk);
    host_rst_ni = 1'b1;
    repeat (17) @(posedge clk);
    @(negedge clk);
    chk("R9 host held", dom[6], 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R9 host released", dom, 8'h00);
    d3cold = 1'b0;
  endtask

  task automatic t_d3(input logic a, input logic p, input logic exp_phy);
    aux = a; pme_en = p;
    fire(3);
    chk("R6 entry map", dom, exp_phy ? M_PHY : 8'h00);
    wait_idle("R6");
    fire(4);
    chk("R8 exit map", dom, M_EXIT | (exp_phy ? M_PHY : 8'h00));
    chk("R7 exit phy", phy_r, exp_phy);
    chk("R8 keep low", sys_keep, 1'b0);
    wait_idle("R8");
    fire(4);
    chk("R7 record cleared", phy_r, 1'b0);
    wait_idle("R7");
    aux = 1'b1; pme_en = 1'b1;
  endtask

  task automatic t_sw_during_exit();
    fire(4);
    fire(0);
    chk("R2 hard wins keep", sys_keep, 1'b0);
    wait_idle("R2");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    t_por();
    t_sw();
    t_sw_rewrite();
    t_phy_hard();
    t_phy_soft();
    t_host(1'b0);
    t_host(1'b1);
    t_d3(1'b1, 1'b1, 1'b0);
    t_d3(1'b0, 1'b1, 1'b1);
    t_d3(1'b1, 1'b0, 1'b1);
    t_sw_during_exit();
    report();
  end
endmodule